// File: doc/BRIEF.md
# Leading-Edge Pulse Time Finder

This block watches one digitised channel record and reports when the pulse's rising edge crosses a low timing threshold, with a resolution of one tenth of a sample. A start pulse latches a high and a low threshold. The block then scans incoming samples for the first one that reaches the high threshold and captures a 15-sample window around it. From that window it works backwards to a coarse low-threshold crossing. It evaluates eight cubic-interpolated points around that crossing, searches them from the late end, and refines the time with a short iterative division.

Every record produces exactly one result: a one-cycle `done_o` strobe with a time and a 2-bit quality code. There are three failures. The high threshold may never be reached. The backward search may run out of window. The interpolated curve may already sit at or below the low threshold at its last point. The last case gives a rough coarse time with a nonzero code instead of an interpolated one.

Top module: `lef_time_finder`

## Requirements
- R1: After reset `busy_o`, `done_o`, `time_o` and `err_o` are 0. `start_i` seen while idle latches `thr_hi_i`/`thr_lo_i` and raises `busy_o` on the next cycle. `start_i` while busy has no effect on the running record or its result.
- R2: Record samples are numbered 0,1,2,… in the order they are accepted (`sample_valid_i` high while busy and collecting). Crossing sample c is the first with index at most REC_LEN-6 whose value is >= the high threshold. Window slot j (0..14) holds record sample c-9+j, so the crossing is in slot 9. A slot before the record start reads as 0. After c, five more samples are accepted and further samples are ignored.
- R3: If none of samples 0..REC_LEN-6 reaches the high threshold, the result has `err_o`=1 and `time_o`=0. `done_o` rises right after the clock edge that accepts sample REC_LEN-6.
- R4: The coarse index k is the first slot, stepping from 8 down to 2, whose value is <= the low threshold. The coarse time is 10*k in tenths of a sample.
- R5: If slots 8 down to 2 are all above the low threshold, the result has `err_o`=2 and `time_o`=0.
- R6: Point p (0..7) lies at position k-0.2+0.2p. Let q=4+p, b=k-1+q/5 and f=q mod 5. The point is the sum over m=0..3 of slot(b-1+m)*w_m(f). The weights are w0=-25f+10f²-f³, w1=250-25f²+3f³, w2=25f+20f²-3f³ and w3=-5f²+f³. A negative sum becomes 0. Otherwise the result is (sum+125)/250, rounded down. Points 1 and 6 therefore equal slots k and k+1 exactly.
- R7: Points are searched from 7 down to 0 for the first one <= the low threshold. If point 7 already qualifies, the result has `err_o`=3 and `time_o`=10*k.
- R8: Otherwise, with p the found point, the fraction is found by repeated addition of (u[p+1]-u[p]) into a running sum. Each addition is kept only if the sum stays <= 2*(lo-u[p]), and at most FRAC_LIMIT additions are made. Then `time_o`=10*k+2p-2+additions and `err_o`=0.
- R9: `done_o` is high for exactly one cycle per record and `busy_o` falls in that same cycle. Latency is counted in clock edges after the edge that accepts the last needed sample. It is 0 for code 1, 7 for code 2, 10-k for code 3, and (9-k)+(8-p)+(additions+1) for code 0.
- R10: Samples presented while idle are ignored: no strobe and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a record; latches thresholds when idle |
| sample_valid_i | input | 1 | Sample qualifier |
| sample_i | input | SAMPLE_W | Unsigned ADC sample |
| thr_hi_i | input | SAMPLE_W | High (trigger) threshold |
| thr_lo_i | input | SAMPLE_W | Low (timing) threshold |
| busy_o | output | 1 | Record in progress |
| done_o | output | 1 | One-cycle result strobe |
| time_o | output | TIME_W | Leading-edge time in tenths of a sample |
| err_o | output | 2 | 0 ok, 1 no high crossing, 2 no low crossing, 3 guard (rough time) |

## Verification
A result arrives at a data-dependent delay. That delay is a fixed function of the coarse index, the found point and the number of fraction additions, given in R9. The bench computes it from the same requirement-level model that yields the expected time and code. It feeds only the samples up to the last needed one, then counts clock edges until the strobe and compares the count with the model. Meanwhile it keeps presenting junk samples, which must not alter the result. Outputs are sampled on falling edges, so each check sees the value set by the preceding rising edge.

// File: rtl/lef_pkg.sv
package lef_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NO_HIGH = 2'd1,
    ERR_NO_LOW  = 2'd2,
    ERR_GUARD   = 2'd3
  } lef_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_POST, ST_COARSE, ST_UPS, ST_FRAC
  } lef_state_e;

  localparam int WIN_LEN        = 15;
  localparam int CROSS_SLOT     = 9;
  localparam int COARSE_MIN     = 2;
  localparam int UPS_LAST       = 7;
  localparam int PTS_PER_SAMPLE = 5;
  localparam int WEIGHT_SUM     = 250;

  // cubic tap weights at fractional offset frac/5, scaled by WEIGHT_SUM
  function automatic int tap_weight(input int frac, input int tap);
    int w;
    case (frac)
      1: case (tap) 0: w = -16; 1: w = 228; 2: w = 42;  default: w = -4;  endcase
      2: case (tap) 0: w = -18; 1: w = 174; 2: w = 106; default: w = -12; endcase
      3: case (tap) 0: w = -12; 1: w = 106; 2: w = 174; default: w = -18; endcase
      4: case (tap) 0: w = -4;  1: w = 42;  2: w = 228; default: w = -16; endcase
      default: w = (tap == 1) ? WEIGHT_SUM : 0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/lef_window.sv
module lef_window #(
  parameter int SW  = 12,
  parameter int LEN = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    shift_i,
  input  logic [SW-1:0]           din_i,
  output logic [LEN-1:0][SW-1:0]  win_o
);
  logic [LEN-1:0][SW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (clear_i) begin
      win_q <= '0;
    end else if (shift_i) begin
      for (int j = 0; j < LEN - 1; j++) win_q[j] <= win_q[j+1];
      win_q[LEN-1] <= din_i;
    end
  end

  assign win_o = win_q;
endmodule

// File: rtl/lef_upsampler.sv
module lef_upsampler
  import lef_pkg::*;
#(
  parameter int SW  = 12,
  parameter int LEN = 15
) (
  input  logic [LEN-1:0][SW-1:0] win_i,
  input  logic [3:0]             k_i,
  input  logic [2:0]             p_i,
  output logic [SW:0]            val_o
);
  localparam int TAPS = 4;

  int q, seg, frac, base, sum;

  always_comb begin
    q    = PTS_PER_SAMPLE - 1 + int'(p_i);
    seg  = q / PTS_PER_SAMPLE;
    frac = q % PTS_PER_SAMPLE;
    base = int'(k_i) - 2 + seg;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [SW-1:0] smp;
    logic [3:0]    idx;
    int            prod;
    always_comb begin
      idx = 4'(base + t);
      smp = '0;
      if ((base + t) >= 0 && (base + t) < LEN) smp = win_i[idx];
      prod = tap_weight(frac, t) * int'({1'b0, smp});
    end
  end

  always_comb begin
    sum = g_tap[0].prod + g_tap[1].prod + g_tap[2].prod + g_tap[3].prod;
    if (sum < 0) val_o = '0;
    else         val_o = (SW+1)'((sum + WEIGHT_SUM / 2) / WEIGHT_SUM);
  end
endmodule

// File: rtl/lef_interp.sv
module lef_interp #(
  parameter int VW    = 13,
  parameter int LIMIT = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [VW+1:0]              num_i,
  input  logic [VW-1:0]              den_i,
  output logic                       fin_o,
  output logic [$clog2(LIMIT+1)-1:0] cnt_o
);
  localparam int AW = VW + 2;
  localparam int CW = $clog2(LIMIT + 1);

  logic          active_q, can_add;
  logic [AW-1:0] acc_q, num_q;
  logic [VW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic [AW:0]   trial;

  always_comb begin
    trial   = {1'b0, acc_q} + (AW+1)'(den_q);
    can_add = (trial <= {1'b0, num_q}) && (cnt_q < CW'(LIMIT));
    fin_o   = active_q && !can_add;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      acc_q    <= '0;
      num_q    <= '0;
      den_q    <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      acc_q    <= '0;
      num_q    <= num_i;
      den_q    <= den_i;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (can_add) begin
        acc_q <= trial[AW-1:0];
        cnt_q <= cnt_q + 1'b1;
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  assign cnt_o = cnt_q;

  a_r8_frac_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
  a_r8_sum_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> acc_q <= num_q);
endmodule

// File: rtl/lef_time_finder.sv
module lef_time_finder
  import lef_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int REC_LEN    = 64,
  parameter int FRAC_LIMIT = 8,
  parameter int TIME_W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_hi_i,
  input  logic [SAMPLE_W-1:0] thr_lo_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [TIME_W-1:0]   time_o,
  output logic [1:0]          err_o
);
  localparam int VAL_W       = SAMPLE_W + 1;
  localparam int IDX_W       = $clog2(REC_LEN);
  localparam int SCAN_LAST   = REC_LEN - 6;
  localparam int POST_LEN    = WIN_LEN - 1 - CROSS_SLOT;
  localparam int COARSE_TOP  = CROSS_SLOT - 1;
  localparam int CNT_W       = $clog2(FRAC_LIMIT + 1);

  lef_state_e                        state_q;
  logic [SAMPLE_W-1:0]               hi_q, lo_q;
  logic [IDX_W-1:0]                  rec_idx_q;
  logic [2:0]                        post_q;
  logic [3:0]                        k_q;
  logic [2:0]                        p_q;
  logic [VAL_W-1:0]                  prev_q;
  logic                              done_q;
  logic [TIME_W-1:0]                 time_q;
  lef_err_e                          err_q;

  logic [WIN_LEN-1:0][SAMPLE_W-1:0]  win_w;
  logic [VAL_W-1:0]                  ups_val;
  logic                              shift, clear, coarse_hit, ups_hit;
  logic                              frac_load, frac_fin;
  logic [VAL_W+1:0]                  frac_num;
  logic [VAL_W-1:0]                  frac_den;
  logic [CNT_W-1:0]                  frac_cnt;
  logic                              fin;
  lef_err_e                          fin_err;
  logic [TIME_W-1:0]                 fin_time;

  always_comb begin
    shift      = sample_valid_i && (state_q == ST_SCAN || state_q == ST_POST);
    clear      = start_i && (state_q == ST_IDLE);
    coarse_hit = win_w[k_q] <= lo_q;
    ups_hit    = ups_val <= {1'b0, lo_q};
    frac_load  = (state_q == ST_UPS) && ups_hit && (p_q != 3'(UPS_LAST));
    frac_num   = {({1'b0, lo_q} - ups_val), 1'b0};
    frac_den   = prev_q - ups_val;
  end

  lef_window #(.SW(SAMPLE_W), .LEN(WIN_LEN)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .shift_i (shift),
    .din_i   (sample_i),
    .win_o   (win_w)
  );

  lef_upsampler #(.SW(SAMPLE_W), .LEN(WIN_LEN)) u_ups (
    .win_i (win_w),
    .k_i   (k_q),
    .p_i   (p_q),
    .val_o (ups_val)
  );

  lef_interp #(.VW(VAL_W), .LIMIT(FRAC_LIMIT)) u_interp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frac_load),
    .num_i  (frac_num),
    .den_i  (frac_den),
    .fin_o  (frac_fin),
    .cnt_o  (frac_cnt)
  );

  // terminal decisions
  always_comb begin
    fin      = 1'b0;
    fin_err  = ERR_NONE;
    fin_time = '0;
    case (state_q)
      ST_SCAN:
        if (sample_valid_i && sample_i < hi_q && rec_idx_q == IDX_W'(SCAN_LAST)) begin
          fin     = 1'b1;
          fin_err = ERR_NO_HIGH;
        end
      ST_COARSE:
        if (!coarse_hit && k_q == 4'(COARSE_MIN)) begin
          fin     = 1'b1;
          fin_err = ERR_NO_LOW;
        end
      ST_UPS:
        if (ups_hit && p_q == 3'(UPS_LAST)) begin
          fin      = 1'b1;
          fin_err  = ERR_GUARD;
          fin_time = TIME_W'(int'(k_q) * 10);
        end
      ST_FRAC:
        if (frac_fin) begin
          fin      = 1'b1;
          fin_time = TIME_W'(int'(k_q) * 10 + int'(p_q) * 2 - 2 + int'(frac_cnt));
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      hi_q      <= '0;
      lo_q      <= '0;
      rec_idx_q <= '0;
      post_q    <= '0;
      k_q       <= '0;
      p_q       <= '0;
      prev_q    <= '0;
      done_q    <= 1'b0;
      time_q    <= '0;
      err_q     <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      if (fin) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        err_q   <= fin_err;
        time_q  <= fin_time;
      end else begin
        case (state_q)
          ST_IDLE:
            if (start_i) begin
              state_q   <= ST_SCAN;
              hi_q      <= thr_hi_i;
              lo_q      <= thr_lo_i;
              rec_idx_q <= '0;
            end
          ST_SCAN:
            if (sample_valid_i) begin
              rec_idx_q <= rec_idx_q + 1'b1;
              if (sample_i >= hi_q) begin
                state_q <= ST_POST;
                post_q  <= 3'(POST_LEN);
              end
            end
          ST_POST:
            if (sample_valid_i) begin
              post_q <= post_q - 1'b1;
              if (post_q == 3'd1) begin
                state_q <= ST_COARSE;
                k_q     <= 4'(COARSE_TOP);
              end
            end
          ST_COARSE:
            if (coarse_hit) begin
              state_q <= ST_UPS;
              p_q     <= 3'(UPS_LAST);
            end else begin
              k_q <= k_q - 1'b1;
            end
          ST_UPS:
            if (ups_hit) begin
              state_q <= ST_FRAC;
            end else begin
              prev_q <= ups_val;
              p_q    <= p_q - 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign time_o = time_q;
  assign err_o  = err_q;

  a_r1_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r2_cross_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COARSE && $past(state_q) == ST_POST) |-> win_w[CROSS_SLOT] >= hi_q);
  a_r6_exact_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UPS && p_q == 3'd1) |-> ups_val == {1'b0, win_w[k_q]});
  a_r7_search_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UPS) |-> p_q != 3'd0);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/lef_time_finder_tb_top.sv
`timescale 1ns/1ps
module lef_time_finder_tb_top;
  localparam int SW  = 12;
  localparam int REC = 64;
  localparam int LIM = 8;
  localparam int TW  = 8;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, sv = 1'b0;
  logic [SW-1:0] smp = '0, hi = '0, lo = '0;
  logic          busy, done;
  logic [TW-1:0] tim;
  logic [1:0]    err;

  int checks = 0, fails = 0;
  int rec[REC];
  bit finished = 0;
  int last_err, last_time;

  always #10 clk = ~clk;

  lef_time_finder #(.SAMPLE_W(SW), .REC_LEN(REC), .FRAC_LIMIT(LIM), .TIME_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sample_valid_i(sv), .sample_i(smp),
    .thr_hi_i(hi), .thr_lo_i(lo), .busy_o(busy), .done_o(done), .time_o(tim), .err_o(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wt(input int f, input int m);
    case (m)
      0: return -25*f + 10*f*f - f*f*f;
      1: return 250 - 25*f*f + 3*f*f*f;
      2: return 25*f + 20*f*f - 3*f*f*f;
      default: return -5*f*f + f*f*f;
    endcase
  endfunction

  task automatic model(input int h, input int l, output int e, output int t,
                       output int lat, output int last);
    int c, k, p, num, den, fr, acc;
    int w[15];
    int u[8];
    c = -1;
    for (int i = 0; i <= REC-6; i++) if (c < 0 && rec[i] >= h) c = i;
    if (c < 0) begin e = 1; t = 0; lat = 0; last = REC-6; return; end
    last = c + 5;
    for (int j = 0; j < 15; j++) w[j] = (c-9+j >= 0) ? rec[c-9+j] : 0;
    k = -1;
    for (int kk = 8; kk >= 2; kk--) if (k < 0 && w[kk] <= l) k = kk;
    if (k < 0) begin e = 2; t = 0; lat = 7; return; end
    for (int pp = 0; pp < 8; pp++) begin
      int q, s, st;
      q = 4 + pp; st = k - 2 + q/5; s = 0;
      for (int m = 0; m < 4; m++) s += w[st+m] * wt(q%5, m);
      u[pp] = (s < 0) ? 0 : (s + 125) / 250;
    end
    if (u[7] <= l) begin e = 3; t = 10*k; lat = 10 - k; return; end
    p = -1;
    for (int pp = 6; pp >= 0; pp--) if (p < 0 && u[pp] <= l) p = pp;
    num = 2*(l - u[p]); den = u[p+1] - u[p]; fr = 0; acc = 0;
    while (acc + den <= num && fr < LIM) begin acc += den; fr++; end
    e = 0; t = 10*k + 2*p - 2 + fr; lat = (9-k) + (8-p) + (fr+1);
  endtask

  task automatic run(input int h, input int l, input bit gaps, input bit poke);
    int e, t, lat, last, n;
    model(h, l, e, t, lat, last);
    @(negedge clk); start = 1; hi = SW'(h); lo = SW'(l);
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    for (int i = 0; i <= last; i++) begin
      if (gaps && $urandom_range(0, 2) == 0) begin
        sv = 0; smp = SW'($urandom_range(0, 4095)); @(negedge clk);
      end
      if (poke && i == 2) begin start = 1; hi = '0; lo = '1; end
      sv = 1; smp = SW'(rec[i]);
      @(negedge clk);
      start = 0; hi = SW'(h); lo = SW'(l);
    end
    n = 0;
    while (!done && n < 100) begin
      smp = SW'($urandom_range(0, 4095)); @(negedge clk); n++;
    end
    sv = 0;
    chk(int'(err) == e, "R3 R5 R7 R8 error code", int'(err), e);
    chk(int'(tim) == t, "R2 R4 R6 R8 time", int'(tim), t);
    chk(n == lat, "R9 latency", n, lat);
    chk(busy === 1'b0, "R9 busy falls with strobe", busy, 0);
    last_err = int'(err); last_time = int'(tim);
    @(negedge clk);
    chk(done === 1'b0, "R9 strobe one cycle", done, 0);
  endtask

  task automatic gen_random(output int h, output int l);
    int base, pos, amp, len, v;
    base = $urandom_range(20, 120);
    pos  = $urandom_range(3, 62);
    amp  = $urandom_range(300, 3500);
    len  = $urandom_range(2, 6);
    for (int i = 0; i < REC; i++) begin
      if (i < pos) v = base + $urandom_range(0, 15);
      else begin
        v = (i - pos + 1 >= len) ? base + amp : base + amp*(i - pos + 1)/len;
        if ($urandom_range(0, 3) == 0) v = v / 3;
      end
      rec[i] = v;
    end
    h = base + $urandom_range(60, 300);
    l = base + $urandom_range(10, 50);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int h, l, bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0, "R1 reset flags", {busy, done}, 0);
    chk(err === 0 && tim === 0, "R1 reset outputs", int'(tim), 0);

    // R10: samples while idle
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      sv = 1; smp = SW'($urandom_range(0, 4095)); hi = 12'd5;
      @(negedge clk);
      if (busy !== 0 || done !== 0) bad++;
    end
    sv = 0;
    chk(bad == 0, "R10 idle samples ignored", bad, 0);

    // R3: crossing just past the scan limit
    for (int i = 0; i < REC; i++) rec[i] = (i >= REC-5) ? 1000 : 50;
    run(500, 80, 0, 0);
    chk(last_err == 1 && last_time == 0, "R3 no high crossing", last_err, 1);

    // R2: crossing at the last scanned index
    for (int i = 0; i < REC; i++) rec[i] = (i >= REC-6) ? 1000 : 50;
    run(500, 80, 1, 0);
    chk(last_err == 0, "R2 crossing at scan limit", last_err, 0);

    // R5: baseline above low threshold
    for (int i = 0; i < REC; i++) rec[i] = (i >= 20) ? 400 : 200;
    run(300, 100, 0, 0);
    chk(last_err == 2 && last_time == 0, "R5 no low crossing", last_err, 2);

    // R7: undershoot before steep rise triggers guard
    for (int i = 0; i < REC; i++) rec[i] = (i <= 17) ? 50 : 3000;
    rec[18] = 100; rec[19] = 112; rec[20] = 300;
    run(250, 110, 0, 0);
    chk(last_err == 3 && last_time == 70, "R7 guard rough time", last_time, 70);

    // R2: early crossing uses zero padding
    for (int i = 0; i < REC; i++) rec[i] = (i >= 3) ? 400 : 10*(i+1);
    run(300, 25, 0, 0);
    chk(last_err == 0, "R2 zero padded window", last_err, 0);

    // R1: start while busy ignored
    gen_random(h, l);
    rec[30] = 4000;
    run(h, l, 0, 1);

    for (int r = 0; r < 60; r++) begin
      gen_random(h, l);
      run(h, l, r[0], r % 7 == 3);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule